// File: doc/BRIEF.md
# Per-Chip Strided Column Translator

Every chip of a DRAM rank listens to the same command and column-address bus, so on its own a broadcast access reads the same column on every chip. This block sits inside each chip and rewrites the broadcast column locally. For read and write commands, the chip flips some of the column's low bits. The bits it flips are those that are set both in a pattern identifier carried with the command and in the chip's own hardwired identifier. The whole rewrite is one AND and one XOR per chip.

Pattern 0 leaves every chip on the broadcast column, which is the plain unit-stride access. The memory controller stores word `w` of cache line `L` on chip `w XOR L`. With that layout, a single read of column 0 under pattern 1, 3 or 7 gathers every 2nd, 4th or 8th value from across the rank. The translated column, the forwarded command and a flag that marks an actual rewrite are registered, so each appears one clock after the inputs.

Top module: `pct_col_xlate`

## Requirements
- R1: While `rst_n` is low, `col_o` is 0, `cmd_o` is the no-operation code 0 and `xlated_o` is 0, whatever the inputs.
- R2: For a READ command (code 2), `col_o` one clock later equals `col_i` with each bit `b` below `ID_W` inverted where bit `b` of `pat_i` and bit `b` of `CHIP_ID` are both 1.
- R3: A WRITE command (code 3) is translated exactly as in R2.
- R4: For any command other than READ or WRITE (codes 0, 1, 4, 5, 6, 7), `col_o` one clock later equals `col_i` unchanged, for any `pat_i`.
- R5: With pattern 0, a READ or WRITE leaves the column unchanged on every chip.
- R6: Column bits at positions `ID_W` and above always pass through unchanged.
- R7: `cmd_o` equals `cmd_i` delayed by one clock.
- R8: `xlated_o` is 1 one clock after the inputs exactly when the command is READ or WRITE and `pat_i AND CHIP_ID` is nonzero, so that `col_o` differs from the input column.
- R9: In an eight-chip rank (CHIP_ID 0..7) holding value `v` at chip `(v mod 8) XOR (v div 8)`, column `v div 8`, a READ of column 0 with pattern `p` returns value `(k AND p)*8 + (k AND NOT p)` from chip `k`. For p = 0, 1, 3 and 7 this is eight distinct multiples of `p+1`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 3 | Broadcast command code (2 READ, 3 WRITE, others pass-through) |
| col_i | input | COL_W | Broadcast column address |
| pat_i | input | ID_W | Broadcast pattern identifier |
| cmd_o | output | 3 | Registered command |
| col_o | output | COL_W | Registered local column address |
| xlated_o | output | 1 | Registered flag: the column was rewritten |

## Verification
The bench builds eight copies at the default COL_W of 10 and ID_W of 3, giving CHIP_ID 0 to 7, so that every pairing of chip bits and pattern bits is exercised in one stimulus. Because the column is wider than the identifier, the upper bits have room to show that they never change. The full rank makes the gather of R9 observable: a bench-side memory laid out with the shuffle is indexed by each chip's output column, and the value returned is compared with a per-chip formula. The check also confirms that the eight values are distinct and form the expected stride.

// File: rtl/pct_pkg.sv
`timescale 1ns/1ps
package pct_pkg;
  localparam int CMD_W = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5
  } pct_cmd_e;

  // Column-access commands are the only ones whose address is rewritten.
  function automatic logic is_col_cmd(input logic [CMD_W-1:0] c);
    return (c == CMD_RD) || (c == CMD_WR);
  endfunction
endpackage

// File: rtl/pct_cmd_filter.sv
`timescale 1ns/1ps
module pct_cmd_filter (
  input  logic [pct_pkg::CMD_W-1:0] cmd_i,
  output logic                      col_cmd_o
);
  assign col_cmd_o = pct_pkg::is_col_cmd(cmd_i);
endmodule

// File: rtl/pct_mask_gen.sv
`timescale 1ns/1ps
module pct_mask_gen #(
  parameter int          ID_W    = 3,
  parameter int unsigned CHIP_ID = 0
) (
  input  logic            en_i,
  input  logic [ID_W-1:0] pat_i,
  output logic [ID_W-1:0] mask_o
);
  localparam logic [ID_W-1:0] ID_BITS = CHIP_ID[ID_W-1:0];

  // One AND per identifier bit, gated by the command class.
  for (genvar b = 0; b < ID_W; b++) begin : g_bit
    assign mask_o[b] = en_i & pat_i[b] & ID_BITS[b];
  end
endmodule

// File: rtl/pct_col_rewrite.sv
`timescale 1ns/1ps
module pct_col_rewrite #(
  parameter int COL_W = 10,
  parameter int ID_W  = 3
) (
  input  logic [COL_W-1:0] col_i,
  input  logic [ID_W-1:0]  mask_i,
  output logic [COL_W-1:0] col_o
);
  localparam int HI_W = COL_W - ID_W;

  assign col_o = {col_i[COL_W-1 -: HI_W], col_i[ID_W-1:0] ^ mask_i};
endmodule

// File: rtl/pct_col_xlate.sv
`timescale 1ns/1ps
module pct_col_xlate #(
  parameter int          COL_W   = 10,
  parameter int          ID_W    = 3,
  parameter int unsigned CHIP_ID = 0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [pct_pkg::CMD_W-1:0] cmd_i,
  input  logic [COL_W-1:0]          col_i,
  input  logic [ID_W-1:0]           pat_i,
  output logic [pct_pkg::CMD_W-1:0] cmd_o,
  output logic [COL_W-1:0]          col_o,
  output logic                      xlated_o
);
  // Named internal events, visible to the bound checker.
  logic                      col_cmd;
  logic [ID_W-1:0]           flip_mask;
  logic [COL_W-1:0]          col_next;
  logic                      rewrite_hit;

  logic [pct_pkg::CMD_W-1:0] cmd_q;
  logic [COL_W-1:0]          col_q;
  logic                      xl_q;

  pct_cmd_filter i_cmd_filter (
    .cmd_i     (cmd_i),
    .col_cmd_o (col_cmd)
  );

  pct_mask_gen #(.ID_W(ID_W), .CHIP_ID(CHIP_ID)) i_mask_gen (
    .en_i   (col_cmd),
    .pat_i  (pat_i),
    .mask_o (flip_mask)
  );

  pct_col_rewrite #(.COL_W(COL_W), .ID_W(ID_W)) i_col_rewrite (
    .col_i  (col_i),
    .mask_i (flip_mask),
    .col_o  (col_next)
  );

  assign rewrite_hit = |flip_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= pct_pkg::CMD_NOP;
      col_q <= '0;
      xl_q  <= 1'b0;
    end else begin
      cmd_q <= cmd_i;
      col_q <= col_next;
      xl_q  <= rewrite_hit;
    end
  end

  assign cmd_o    = cmd_q;
  assign col_o    = col_q;
  assign xlated_o = xl_q;
endmodule

// File: rtl/pct_col_xlate_chk.sv
`timescale 1ns/1ps
module pct_col_xlate_chk #(
  parameter int          COL_W   = 10,
  parameter int          ID_W    = 3,
  parameter int unsigned CHIP_ID = 0
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [pct_pkg::CMD_W-1:0] cmd_i,
  input logic [COL_W-1:0]          col_i,
  input logic [ID_W-1:0]           pat_i,
  input logic [pct_pkg::CMD_W-1:0] cmd_o,
  input logic [COL_W-1:0]          col_o,
  input logic                      xlated_o,
  input logic                      col_cmd,
  input logic [ID_W-1:0]           flip_mask
);
  localparam logic [ID_W-1:0] ID_BITS = CHIP_ID[ID_W-1:0];

  // Set at the first edge taken out of reset: outputs then reflect sampled inputs.
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (col_o == '0 && cmd_o == '0 && !xlated_o));

  // R2 R3
  rdwr_xlate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && pct_pkg::is_col_cmd($past(cmd_i))) |->
      col_o == ($past(col_i) ^ {{(COL_W-ID_W){1'b0}}, $past(pat_i) & ID_BITS}));

  // R4
  other_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !pct_pkg::is_col_cmd($past(cmd_i))) |-> col_o == $past(col_i));

  // R5
  pat_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(pat_i) == '0) |-> col_o == $past(col_i));

  // R6
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> col_o[COL_W-1:ID_W] == $past(col_i[COL_W-1:ID_W]));

  // R7
  cmd_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> cmd_o == $past(cmd_i));

  // R8
  flag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> xlated_o == (col_o != $past(col_i)));

  // R8: mask never set outside a column command
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !col_cmd |-> flip_mask == '0);
endmodule

bind pct_col_xlate pct_col_xlate_chk #(
  .COL_W(COL_W), .ID_W(ID_W), .CHIP_ID(CHIP_ID)
) i_pct_col_xlate_chk (
  .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .col_i(col_i), .pat_i(pat_i),
  .cmd_o(cmd_o), .col_o(col_o), .xlated_o(xlated_o),
  .col_cmd(col_cmd), .flip_mask(flip_mask)
);

// File: tb/test_pct_col_xlate.sv
`timescale 1ns/1ps
module test_pct_col_xlate;
  localparam int COL_W = 10;
  localparam int ID_W  = 3;
  localparam int NCHIP = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [2:0]       cmd_i = '0;
  logic [COL_W-1:0] col_i = '0;
  logic [ID_W-1:0]  pat_i = '0;
  logic [2:0]       cmd_o [NCHIP];
  logic [COL_W-1:0] col_o [NCHIP];
  logic [NCHIP-1:0] xl_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  for (genvar g = 0; g < NCHIP; g++) begin : g_chip
    pct_col_xlate #(.COL_W(COL_W), .ID_W(ID_W), .CHIP_ID(g)) i_pct_col_xlate (
      .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .col_i(col_i), .pat_i(pat_i),
      .cmd_o(cmd_o[g]), .col_o(col_o[g]), .xlated_o(xl_o[g])
    );
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference: walk the low bits and invert where chip and pattern agree.
  function automatic logic [COL_W-1:0] ref_col(input logic [COL_W-1:0] c,
      input logic [2:0] p, input int k, input logic [2:0] cmd);
    logic [COL_W-1:0] r = c;
    logic [2:0] kb = 3'(k);
    if (cmd == 3'd2 || cmd == 3'd3)
      for (int i = 0; i < ID_W; i++)
        if (p[i] && kb[i]) r[i] = ~r[i];
    return r;
  endfunction

  task automatic apply(input logic [2:0] cmd, input logic [COL_W-1:0] c,
      input logic [2:0] p);
    @(negedge clk);
    cmd_i = cmd; col_i = c; pat_i = p;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    cmd_i = 3'd2; col_i = '1; pat_i = 3'd7;
    repeat (3) @(posedge clk);
    #1;
    for (int k = 0; k < NCHIP; k++) begin
      chk(col_o[k] == '0, "R1 col", int'(col_o[k]), 0);
      chk(cmd_o[k] == '0, "R1 cmd", int'(cmd_o[k]), 0);
      chk(!xl_o[k], "R1 flag", int'(xl_o[k]), 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_xlate(input logic [2:0] cmd, input string req);
    logic [COL_W-1:0] cols [3] = '{10'h000, 10'h155, 10'h3FF};
    for (int ci = 0; ci < 3; ci++)
      for (int p = 0; p < 8; p++) begin
        apply(cmd, cols[ci], 3'(p));
        for (int k = 0; k < NCHIP; k++) begin
          logic [COL_W-1:0] e = ref_col(cols[ci], 3'(p), k, cmd);
          chk(col_o[k] == e, req, int'(col_o[k]), int'(e));
          chk(xl_o[k] == (e != cols[ci]), "R8 flag", int'(xl_o[k]), int'(e != cols[ci]));
        end
      end
  endtask

  task automatic t_other();
    logic [2:0] others [6] = '{3'd0, 3'd1, 3'd4, 3'd5, 3'd6, 3'd7};
    for (int i = 0; i < 6; i++) begin
      apply(others[i], 10'h2A7, 3'd7);
      for (int k = 0; k < NCHIP; k++) begin
        chk(col_o[k] == 10'h2A7, "R4 pass", int'(col_o[k]), 'h2A7);
        chk(!xl_o[k], "R8 no flag", int'(xl_o[k]), 0);
        chk(cmd_o[k] == others[i], "R7 cmd", int'(cmd_o[k]), int'(others[i]));
      end
    end
  endtask

  task automatic t_pat0();
    for (int c = 0; c < 2; c++) begin
      apply(c == 0 ? 3'd2 : 3'd3, 10'h1C6, 3'd0);
      for (int k = 0; k < NCHIP; k++)
        chk(col_o[k] == 10'h1C6, "R5 pattern0", int'(col_o[k]), 'h1C6);
    end
  endtask

  task automatic t_upper();
    for (int i = 0; i < 4; i++) begin
      logic [COL_W-1:0] c = COL_W'((i * 'h97) << 2) | COL_W'(i);
      apply(3'd2, c, 3'd7);
      for (int k = 0; k < NCHIP; k++)
        chk(col_o[k][COL_W-1:ID_W] == c[COL_W-1:ID_W], "R6 upper",
            int'(col_o[k][COL_W-1:ID_W]), int'(c[COL_W-1:ID_W]));
    end
  endtask

  task automatic t_cmd_pipe();
    for (int i = 0; i < 8; i++) begin
      apply(3'(i), 10'h0, 3'd1);
      for (int k = 0; k < NCHIP; k++)
        chk(cmd_o[k] == 3'(i), "R7 cmd", int'(cmd_o[k]), i);
    end
  endtask

  task automatic t_gather();
    int mem [NCHIP][NCHIP];
    logic [2:0] pats [4] = '{3'd0, 3'd1, 3'd3, 3'd7};
    // Controller-side shuffle: value v sits on chip (v%8)^(v/8), column v/8.
    for (int v = 0; v < NCHIP * NCHIP; v++)
      mem[(v % 8) ^ (v / 8)][v / 8] = v;
    for (int pi = 0; pi < 4; pi++) begin
      int p = int'(pats[pi]);
      logic [63:0] seen = '0;
      apply(3'd2, 10'h0, pats[pi]);
      for (int k = 0; k < NCHIP; k++) begin
        int got = mem[k][int'(col_o[k]) % NCHIP];
        int e = (k & p) * 8 + (k & ~p & 7);
        chk(col_o[k] < COL_W'(NCHIP), "R9 column range", int'(col_o[k]), k & p);
        chk(got == e, "R9 gathered value", got, e);
        chk(got % (p + 1) == 0, "R9 stride", got % (p + 1), 0);
        seen[got] = 1'b1;
      end
      chk($countones(seen) == NCHIP, "R9 distinct", $countones(seen), NCHIP);
    end
  endtask

  initial begin
    t_reset();
    t_xlate(3'd2, "R2 read");
    t_xlate(3'd3, "R3 write");
    t_other();
    t_pat0();
    t_upper();
    t_cmd_pipe();
    t_gather();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule